// File: doc/BRIEF.md
# Condition Bit to Register Set Unit

This unit executes the family of set-boolean-from-condition operations. It picks one bit out of a 32-bit condition register, which is organised as eight four-bit fields, and turns it into a 64-bit general-register value. That value is 0 or 1 in the plain form, and 0 or all-ones in the negated form. A reverse option inverts the sense of the test before the value is formed.

The bit is addressed by a packed 5-bit index. The upper three bits pick the field and the lower two bits pick the bit inside that field, most significant first. The operations exist only when the newest architecture level is switched on. When it is off, the unit flags the operation as illegal and suppresses the register write.

The result is registered, so each accepted request produces a response exactly one cycle later.

Top module: `csb_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid`, `wr_en` and `illegal` are 0 and `result` is all zeros.
- R2: `out_valid` is high in cycle n+1 exactly when `in_valid` was high in cycle n. All outputs are zero in any cycle in which `out_valid` is low.
- R3: Index bits [4:2] select field f, where field f occupies `cond_reg[31-4f : 28-4f]`, so field 0 is the most significant nibble.
- R4: Index bits [1:0] select bit k of the chosen field, where k = 0 is the field's most significant bit. Overall, index i tests `cond_reg[31-i]`.
- R5: With `reverse`=0 and `negate`=0, `result` is 1 when the tested bit is set and 0 when it is clear.
- R6: With `reverse`=1, the test is inverted: the 0/1 value is 1 when the tested bit is clear.
- R7: With `negate`=1, the 0/1 value is two's-complement negated, so `result` is all-ones (64'hFFFF_FFFF_FFFF_FFFF) or 0.
- R8: With `isa_enable`=0, a valid request gives `illegal`=1, `wr_en`=0 and `result`=0, whatever the other inputs are.
- R9: A valid request with `isa_enable`=1 gives `wr_en`=1 and `illegal`=0. `wr_en` and `illegal` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| cond_reg | input | 32 | Condition register value, field 0 in the top nibble |
| bit_idx | input | 5 | Packed field/bit index of the bit to test |
| negate | input | 1 | Produce 0 / all-ones instead of 0 / 1 |
| reverse | input | 1 | Invert the sense of the test |
| isa_enable | input | 1 | Newest architecture level is enabled |
| out_valid | output | 1 | Response present this cycle |
| result | output | 64 | Value to write to the general register |
| wr_en | output | 1 | Register write permitted |
| illegal | output | 1 | Operation is illegal at the current level |

## Verification
The assertions assume that reset is held high from time zero until after the first clock edge. They also assume that every input is settled and free of X on each rising edge. Nothing is assumed about the order of requests: back-to-back requests, gaps and a toggling enable are all legal. The stimulus drives every input on the falling edge only and holds reset through the opening edges. It then mixes idle cycles, a walking-one and a walking-zero sweep over all 32 indices in every mode combination, and pseudo-random patterns with the enable both on and off.

// File: rtl/csb_pkg.sv
package csb_pkg;

    localparam int unsigned CSB_XLEN    = 64;
    localparam int unsigned CSB_NFIELD  = 8;
    localparam int unsigned CSB_FWIDTH  = 4;
    localparam int unsigned CSB_CRWIDTH = CSB_NFIELD * CSB_FWIDTH;
    localparam int unsigned CSB_IDXW    = $clog2(CSB_CRWIDTH);

    typedef struct packed {
        logic                   valid;
        logic [CSB_CRWIDTH-1:0] cr;
        logic [CSB_IDXW-1:0]    idx;
        logic                   neg;
        logic                   rev;
        logic                   ena;
    } csb_req_t;

    typedef struct packed {
        logic                valid;
        logic                wr;
        logic                ill;
        logic [CSB_XLEN-1:0] value;
    } csb_resp_t;

    // Turn a 0/1 flag into either a zero-extended 1 or an all-ones word.
    function automatic logic [CSB_XLEN-1:0] csb_shape(input logic b, input logic neg);
        logic [CSB_XLEN-1:0] v;
        if (neg) v = {CSB_XLEN{b}};
        else     v = {{(CSB_XLEN-1){1'b0}}, b};
        return v;
    endfunction

endpackage

// File: rtl/csb_field_pick.sv
module csb_field_pick #(
    parameter int unsigned NFIELD = csb_pkg::CSB_NFIELD,
    parameter int unsigned FWIDTH = csb_pkg::CSB_FWIDTH,
    localparam int unsigned CRW   = NFIELD * FWIDTH,
    localparam int unsigned FSELW = $clog2(NFIELD),
    localparam int unsigned BSELW = $clog2(FWIDTH)
) (
    input  logic [CRW-1:0]         cr,
    input  logic [FSELW+BSELW-1:0] idx,
    output logic                   bit_out
);
    logic [FWIDTH-1:0] fields [NFIELD];
    logic [FWIDTH-1:0] chosen;
    logic [FSELW-1:0]  fsel;
    logic [BSELW-1:0]  bsel;

    // Field 0 sits in the most significant nibble.
    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        assign fields[f] = cr[CRW-1-f*FWIDTH -: FWIDTH];
    end

    assign fsel   = idx[FSELW+BSELW-1:BSELW];
    assign bsel   = idx[BSELW-1:0];
    assign chosen = fields[fsel];
    // Bit 0 of the field is its most significant bit.
    assign bit_out = chosen[FWIDTH-1-bsel];

endmodule

// File: rtl/csb_shaper.sv
module csb_shaper
    import csb_pkg::*;
(
    input  logic                tested,
    input  logic                rev,
    input  logic                neg,
    input  logic                ena,
    output logic [CSB_XLEN-1:0] value
);
    logic cond_true;

    always_comb begin
        cond_true = tested ^ rev;
        value     = ena ? csb_shape(cond_true, neg) : '0;
    end

endmodule

// File: rtl/csb_out_reg.sv
module csb_out_reg
    import csb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_in,
    input  logic                ena,
    input  logic [CSB_XLEN-1:0] value_in,
    output csb_resp_t           resp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '0;
        end else if (valid_in) begin
            resp.valid <= 1'b1;
            resp.wr    <= ena;
            resp.ill   <= ~ena;
            resp.value <= value_in;
        end else begin
            resp <= '0;
        end
    end

    // R9
    wr_ill_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(resp.wr && resp.ill));

endmodule

// File: rtl/csb_unit.sv
module csb_unit
    import csb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [CSB_CRWIDTH-1:0] cond_reg,
    input  logic [CSB_IDXW-1:0]    bit_idx,
    input  logic                   negate,
    input  logic                   reverse,
    input  logic                   isa_enable,
    output logic                   out_valid,
    output logic [CSB_XLEN-1:0]    result,
    output logic                   wr_en,
    output logic                   illegal
);
    csb_req_t            req;
    csb_resp_t           resp;
    logic                tested;
    logic [CSB_XLEN-1:0] shaped;

    always_comb begin
        req.valid = in_valid;
        req.cr    = cond_reg;
        req.idx   = bit_idx;
        req.neg   = negate;
        req.rev   = reverse;
        req.ena   = isa_enable;
    end

    csb_field_pick #(
        .NFIELD (CSB_NFIELD),
        .FWIDTH (CSB_FWIDTH)
    ) u_pick (
        .cr      (req.cr),
        .idx     (req.idx),
        .bit_out (tested)
    );

    csb_shaper u_shape (
        .tested (tested),
        .rev    (req.rev),
        .neg    (req.neg),
        .ena    (req.ena),
        .value  (shaped)
    );

    csb_out_reg u_oreg (
        .clk      (clk),
        .rst      (rst),
        .valid_in (req.valid),
        .ena      (req.ena),
        .value_in (shaped),
        .resp     (resp)
    );

    assign out_valid = resp.valid;
    assign wr_en     = resp.wr;
    assign illegal   = resp.ill;
    assign result    = resp.value;

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!wr_en && !illegal && result == '0));

    // R8
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !$past(isa_enable)) |->
        (illegal && !wr_en && result == '0));

    // R7
    negate_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(negate)) |->
        (result == '0 || result == '1));

    // R5
    plain_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !$past(negate)) |->
        (result[CSB_XLEN-1:1] == '0));

endmodule

// File: tb/csb_unit_tb.sv
`timescale 1ns/1ps
module csb_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] cond_reg = '0;
    logic [4:0]  bit_idx = '0;
    logic        negate = 1'b0;
    logic        reverse = 1'b0;
    logic        isa_enable = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        wr_en;
    logic        illegal;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // Expected response for the next sampling point
    logic        e_valid = 1'b0;
    logic        e_wr = 1'b0;
    logic        e_ill = 1'b0;
    logic [63:0] e_res = '0;
    string       e_tag = "R1";

    always #4 clk = ~clk;

    csb_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .cond_reg   (cond_reg),
        .bit_idx    (bit_idx),
        .negate     (negate),
        .reverse    (reverse),
        .isa_enable (isa_enable),
        .out_valid  (out_valid),
        .result     (result),
        .wr_en      (wr_en),
        .illegal    (illegal)
    );

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL R2 watchdog expired: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Compare the outputs against the expectation (called at a falling edge)
    task automatic check_outputs();
        tests++;
        if (out_valid !== e_valid || wr_en !== e_wr || illegal !== e_ill || result !== e_res) begin
            fails++;
            $display("FAIL %s: actual v=%0b wr=%0b ill=%0b res=%h expected v=%0b wr=%0b ill=%0b res=%h",
                     e_tag, out_valid, wr_en, illegal, result, e_valid, e_wr, e_ill, e_res);
        end
    endtask

    // Behavioural model of the requirements: index i tests cond_reg[31-i] (R3 R4)
    task automatic predict(input logic v, input logic [31:0] cr, input int idx,
                           input logic neg, input logic rev, input logic ena, input string tag);
        logic b;
        e_tag = tag;
        if (!v) begin
            e_valid = 0; e_wr = 0; e_ill = 0; e_res = '0;
        end else if (!ena) begin
            e_valid = 1; e_wr = 0; e_ill = 1; e_res = '0;   // R8
        end else begin
            b = cr[31 - idx];
            if (rev) b = !b;                              // R6
            e_valid = 1; e_wr = 1; e_ill = 0;             // R9
            if (neg) e_res = b ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0;  // R7
            else     e_res = b ? 64'h1 : 64'h0;           // R5
        end
    endtask

    // One cycle: check the previous response, then drive the next request
    task automatic step(input logic v, input logic [31:0] cr, input int idx,
                        input logic neg, input logic rev, input logic ena, input string tag);
        @(negedge clk);
        check_outputs();
        in_valid   = v;
        cond_reg   = cr;
        bit_idx    = idx[4:0];
        negate     = neg;
        reverse    = rev;
        isa_enable = ena;
        predict(v, cr, idx, neg, rev, ena, tag);
    endtask

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'hACE1_2345;
        // R1: reset with a request presented; outputs must stay clear
        @(negedge clk);
        in_valid = 1; isa_enable = 1; cond_reg = '1;
        @(negedge clk);
        check_outputs();
        @(negedge clk);
        check_outputs();
        rst = 0;
        in_valid = 0;
        predict(0, '0, 0, 0, 0, 0, "R1");
        // R2: idle cycles, then back-to-back requests
        step(0, 32'h8000_0000, 0, 0, 0, 1, "R2");
        step(1, 32'h8000_0000, 0, 0, 0, 1, "R2 R5");
        step(1, 32'h8000_0000, 1, 0, 0, 1, "R2 R5");
        step(0, 32'h0, 0, 0, 0, 1, "R2");
        // R3 R4: walking one and walking zero across all indices and modes
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 32; p++) begin
                for (int q = 0; q < 32; q += 7) begin
                    step(1, 32'h1 << p, q, m[1], m[0], 1, "R3 R4");
                end
                step(1, ~(32'h1 << p), 31 - p, m[1], m[0], 1, "R3 R4 R6 R7");
                step(1, 32'h1 << p, 31 - p, m[1], m[0], 1, "R3 R4 R5 R7");
            end
        end
        // R8: illegal at disabled level, with every mode
        for (int m = 0; m < 8; m++) begin
            step(1, '1, m * 4, m[1], m[0], 0, "R8");
        end
        // R9 R6 R7: random mix including enable toggling and gaps
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[3] | lfsr[9], lfsr ^ {lfsr[15:0], lfsr[31:16]}, int'(lfsr[8:4]),
                 lfsr[11], lfsr[13], lfsr[17] | lfsr[2], "R9 R6 R7");
        end
        step(0, '0, 0, 0, 0, 0, "R2");
        step(0, '0, 0, 0, 0, 0, "R2");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule